// File: doc/BRIEF.md
# Acquisition Trigger and Autoscan Sequencer

This block decides when the analog-to-digital converter starts a conversion and which multiplexer channel that conversion samples. A host writes a small set of registers to choose a start source: host software writes, ticks from an external pacer timer, or rising edges on an external trigger pin. The block then issues a one-cycle convert-start strobe together with the channel number to sample. A start request that arrives while the converter reports busy is dropped.

In scan mode, a channel counter steps upward from channel 0 to a programmed last channel and then returns to 0. Outside scan mode, the channel register itself names the one channel that is converted every time. The block also routes converter and trigger events onto two interrupt lines according to two select bits. The pacer counter and the converter are outside this block.

Top module: `acq_trigger_seq`

## Requirements
- R1: After a synchronous active-low reset, `conv_start`, `irq_a` and `irq_b` are 0 and `conv_chan` is 0. All registers clear, which selects software triggering with scan off.
- R2: Register address 0 is trigger control: bit 0 turns scan on, bit 1 selects the pacer and bit 2 selects the external trigger. When bits 1 and 2 are both 0, a write of any data to address 3 causes `conv_start` to be 1 on the cycle after the write. Pacer ticks and external edges then cause no strobe.
- R3: With control bit 1 set and bit 2 clear, a `pacer_tick` pulse gives a `conv_start` pulse one cycle later. Software writes and external edges are then ignored.
- R4: With control bit 2 set, whatever bit 1 holds, a rising edge on `ext_trig` gives a single `conv_start` pulse one cycle later. Holding `ext_trig` high gives no further pulse, and pacer ticks are ignored.
- R5: A trigger seen while `conv_busy` is 1 produces no strobe and does not advance the scan channel.
- R6: With scan on, the channel register at address 1 holds the last channel (channel count minus 1). Successive strobes carry channels 0, 1, …, last, then 0 again.
- R7: With scan off, every strobe carries the channel held in the channel register.
- R8: A write to the channel register sets the scan counter back to 0, so the next scanned strobe carries channel 0.
- R9: Address 2 bit 0 selects the source of `irq_a`: 0 gives a pulse for each `conv_done`, 1 gives a pulse on each rising edge of `fifo_half`. Either pulse comes one cycle after its cause.
- R10: Address 2 bit 1 selects the source of `irq_b`: 0 gives a pulse for each `pacer_tick`, 1 gives a pulse for each rising edge of `ext_trig`. Either pulse comes one cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 channel, 2 interrupt select, 3 soft trigger |
| wr_data | input | 8 | Register write data |
| pacer_tick | input | 1 | One-cycle tick from the pacer timer |
| ext_trig | input | 1 | External trigger level |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | One-cycle end-of-conversion pulse |
| fifo_half | input | 1 | Sample FIFO half-full level |
| conv_start | output | 1 | One-cycle convert-start strobe |
| conv_chan | output | 4 | Channel for the conversion just started |
| irq_a | output | 1 | First interrupt pulse |
| irq_b | output | 1 | Second interrupt pulse |

## Verification
A scan counter that is wrong, or that wraps at the wrong point, shows up on `conv_chan` at the first strobe after the fault. The bench therefore sweeps every last-channel value through more than two full wraps. A wrong source decode or missing busy gating shows up on `conv_start` one cycle after the offending stimulus, and each source is driven while its rivals are also active. Interrupt routing errors appear on `irq_a` or `irq_b` one cycle after the event, and both settings of each select bit are checked.

// File: rtl/acq_seq_pkg.sv
// Shared definitions for the acquisition trigger sequencer.
// Assumes a two-bit register address space.
package acq_seq_pkg;
    typedef enum logic [1:0] {
        REG_TRIG   = 2'd0,
        REG_CHAN   = 2'd1,
        REG_IRQSEL = 2'd2,
        REG_SOFT   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2
    } trig_src_e;

    localparam int CTRL_SCAN_BIT = 0;
    localparam int CTRL_PACE_BIT = 1;
    localparam int CTRL_EXT_BIT  = 2;
    localparam int CTRL_W        = 3;
    localparam int ISEL_W        = 2;
endpackage

// File: rtl/acq_trig_select.sv
// Picks the active start source and gates it with converter busy.
// Assumes pacer_tick is a one-cycle pulse and ext_trig is a synchronous level.
module acq_trig_select
    import acq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pace_sel,
    input  logic ext_sel,
    input  logic soft_pulse,
    input  logic pacer_tick,
    input  logic ext_trig,
    input  logic conv_busy,
    output logic fire,
    output logic ext_rise
);
    logic      ext_q;
    trig_src_e src;
    logic      cand;

    // Remembers the previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    assign ext_rise = ext_trig & ~ext_q;

    // Decodes the source; external wins over pacer.
    always_comb begin
        if (ext_sel)       src = SRC_EXT;
        else if (pace_sel) src = SRC_PACER;
        else               src = SRC_SOFT;
    end

    // Selects the candidate request from the chosen source.
    always_comb begin
        case (src)
            SRC_EXT:   cand = ext_rise;
            SRC_PACER: cand = pacer_tick;
            default:   cand = soft_pulse;
        endcase
    end

    assign fire = cand & ~conv_busy;
endmodule

// File: rtl/acq_scan_ctr.sv
// Channel sequencer: counts 0..limit in scan mode, else passes the fixed channel.
// Assumes clear has priority over advance.
module acq_scan_ctr #(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic [CHAN_W-1:0] limit,
    input  logic              clear,
    input  logic              advance,
    output logic [CHAN_W-1:0] chan_now,
    output logic [CHAN_W-1:0] cnt_o
);
    logic [CHAN_W-1:0] cnt;

    // Steps the scan counter on each accepted start, wrapping after limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (clear)              cnt <= '0;
        else if (advance && scan_en) cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
    end

    assign chan_now = scan_en ? cnt : limit;
    assign cnt_o    = cnt;
endmodule

// File: rtl/acq_irq_route.sv
// Routes converter and trigger events onto two registered interrupt pulses.
// Assumes conv_done and pacer_tick are one-cycle pulses.
module acq_irq_route
    import acq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ISEL_W-1:0] isel,
    input  logic              conv_done,
    input  logic              fifo_half,
    input  logic              pacer_tick,
    input  logic              ext_rise,
    output logic              irq_a,
    output logic              irq_b
);
    logic half_q;

    // Registers the half-full level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= fifo_half;
    end

    // Registers the selected event of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_a <= 1'b0;
            irq_b <= 1'b0;
        end else begin
            irq_a <= isel[0] ? (fifo_half & ~half_q) : conv_done;
            irq_b <= isel[1] ? ext_rise : pacer_tick;
        end
    end
endmodule

// File: rtl/acq_trigger_seq.sv
// Top: host registers, start-source selection, channel sequencing, interrupt routing.
// Assumes synchronous host writes and synchronous trigger inputs.
module acq_trigger_seq
    import acq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic              fifo_half,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              irq_a,
    output logic              irq_b
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CHAN_W-1:0] lim_q;
    logic [ISEL_W-1:0] isel_q;
    logic              soft_wr;
    logic              chan_wr;
    logic              fire;
    logic              ext_rise;
    logic [CHAN_W-1:0] chan_now;
    logic [CHAN_W-1:0] scan_cnt;

    assign soft_wr = wr_en && (wr_addr == REG_SOFT);
    assign chan_wr = wr_en && (wr_addr == REG_CHAN);

    // Holds the host-written control, channel and interrupt-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lim_q  <= '0;
            isel_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_TRIG:   ctrl_q <= wr_data[CTRL_W-1:0];
                REG_CHAN:   lim_q  <= wr_data[CHAN_W-1:0];
                REG_IRQSEL: isel_q <= wr_data[ISEL_W-1:0];
                default:    ;
            endcase
        end
    end

    acq_trig_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .pace_sel   (ctrl_q[CTRL_PACE_BIT]),
        .ext_sel    (ctrl_q[CTRL_EXT_BIT]),
        .soft_pulse (soft_wr),
        .pacer_tick (pacer_tick),
        .ext_trig   (ext_trig),
        .conv_busy  (conv_busy),
        .fire       (fire),
        .ext_rise   (ext_rise)
    );

    acq_scan_ctr #(.CHAN_W(CHAN_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (ctrl_q[CTRL_SCAN_BIT]),
        .limit    (lim_q),
        .clear    (chan_wr),
        .advance  (fire),
        .chan_now (chan_now),
        .cnt_o    (scan_cnt)
    );

    acq_irq_route u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .isel       (isel_q),
        .conv_done  (conv_done),
        .fifo_half  (fifo_half),
        .pacer_tick (pacer_tick),
        .ext_rise   (ext_rise),
        .irq_a      (irq_a),
        .irq_b      (irq_b)
    );

    // Issues the start strobe and latches the channel it samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= fire;
            if (fire) conv_chan <= chan_now;
        end
    end
endmodule

// File: rtl/acq_trigger_seq_chk.sv
// Checker for the trigger sequencer, bound to the top module.
// Assumes the internal register and counter names of the top.
module acq_trigger_seq_chk #(
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              conv_busy,
    input logic              conv_start,
    input logic              conv_done,
    input logic              irq_a,
    input logic [2:0]        ctrl_q,
    input logic [1:0]        isel_q,
    input logic [CHAN_W-1:0] lim_q,
    input logic [CHAN_W-1:0] scan_cnt
);
    // Busy drops a request.
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> !conv_start);

    // In software mode only a soft-trigger write starts a conversion.
    assert_soft_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2:1] == 2'b00 && !(wr_en && wr_addr == 2'd3)) |=> !conv_start);

    // The scan counter never passes the last channel.
    assert_scan_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_cnt <= lim_q);

    // A channel write restarts the scan.
    assert_chan_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (scan_cnt == '0));

    // With end-of-conversion selected, irq_a only follows conv_done.
    assert_irqa_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!isel_q[0] && !conv_done) |=> !irq_a);
endmodule

bind acq_trigger_seq acq_trigger_seq_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .conv_busy  (conv_busy),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .irq_a      (irq_a),
    .ctrl_q     (ctrl_q),
    .isel_q     (isel_q),
    .lim_q      (lim_q),
    .scan_cnt   (scan_cnt)
);

// File: tb/acq_trigger_seq_tb.sv
`timescale 1ns/1ps
module acq_trigger_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pacer_tick = 1'b0;
    logic       ext_trig = 1'b0;
    logic       conv_busy = 1'b0;
    logic       conv_done = 1'b0;
    logic       fifo_half = 1'b0;
    logic       conv_start;
    logic [3:0] conv_chan;
    logic       irq_a;
    logic       irq_b;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    acq_trigger_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .conv_busy(conv_busy),
        .conv_done(conv_done), .fifo_half(fifo_half), .conv_start(conv_start),
        .conv_chan(conv_chan), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
    endtask

    task automatic ext_edge();
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start", conv_start, 0);
        chk("R1 chan", conv_chan, 0);
        chk("R1 irq_a", irq_a, 0);
        chk("R1 irq_b", irq_b, 0);

        // R2: software mode
        wr(0, 0);
        for (int d = 0; d < 4; d++) begin
            wr(3, d * 85);
            chk("R2 soft start", conv_start, 1);
        end
        tick();     chk("R2 pacer ignored", conv_start, 0);
        ext_edge(); chk("R2 ext ignored", conv_start, 0);

        // R7: fixed channel sweep
        for (int c = 0; c < 16; c++) begin
            wr(1, c); wr(3, 0);
            chk("R7 fixed chan", conv_chan, c);
        end

        // R3: pacer mode
        wr(0, 2); wr(1, 5);
        tick();     chk("R3 pacer start", conv_start, 1);
        chk("R3 chan", conv_chan, 5);
        wr(3, 0);   chk("R3 soft ignored", conv_start, 0);
        ext_edge(); chk("R3 ext ignored", conv_start, 0);

        // R4: external mode, bit 2 wins over bit 1
        wr(0, 6);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); chk("R4 ext start", conv_start, 1);
        @(negedge clk); chk("R4 held high", conv_start, 0);
        ext_trig = 1'b0;
        @(negedge clk); chk("R4 low", conv_start, 0);
        tick();         chk("R4 pacer ignored", conv_start, 0);

        // R6: scan sweep over every last channel
        wr(0, 3);
        for (int lim = 0; lim < 16; lim++) begin
            wr(1, lim);
            for (int k = 0; k <= 2 * (lim + 1); k++) begin
                tick();
                chk("R6 scan start", conv_start, 1);
                chk("R6 scan chan", conv_chan, k % (lim + 1));
            end
        end

        // R8: channel write restarts the scan
        wr(1, 7);
        for (int k = 0; k < 3; k++) tick();
        chk("R8 pre", conv_chan, 2);
        wr(1, 7);
        tick(); chk("R8 restart chan", conv_chan, 0);

        // R5: busy drops the request and holds the channel
        wr(1, 3);
        tick(); chk("R5 chan0", conv_chan, 0);
        conv_busy = 1'b1;
        tick(); chk("R5 busy start", conv_start, 0);
        conv_busy = 1'b0;
        tick(); chk("R5 after start", conv_start, 1);
        chk("R5 not advanced", conv_chan, 1);

        // R9: irq_a routing
        wr(2, 0);
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0; chk("R9 eoc irq", irq_a, 1);
        fifo_half = 1'b1;
        @(negedge clk); chk("R9 half ignored", irq_a, 0);
        fifo_half = 1'b0;
        wr(2, 1);
        @(negedge clk); fifo_half = 1'b1;
        @(negedge clk); chk("R9 half irq", irq_a, 1);
        @(negedge clk); chk("R9 half held", irq_a, 0);
        fifo_half = 1'b0; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0; chk("R9 eoc ignored", irq_a, 0);

        // R10: irq_b routing
        wr(2, 0);
        tick();     chk("R10 pacer irq", irq_b, 1);
        ext_edge(); chk("R10 ext ignored", irq_b, 0);
        wr(2, 2);
        ext_edge(); chk("R10 ext irq", irq_b, 1);
        tick();     chk("R10 pacer ignored", irq_b, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule